// File: doc/BRIEF.md
# UART FIFO Interrupt Status Controller

This block sits between a UART's bit-level serializer/deserializer and the register interface that software uses. It stores up to sixteen received characters, each with its break, parity and framing error flags, and up to sixteen bytes waiting to be sent. From the occupancy of the two queues it derives five interrupt sources. Each source has a status bit and an enable bit, and the enabled ones are combined into a single interrupt line.

Software reaches the block through four word registers, selected by a 2-bit address:
- interrupt status/enable at 0,
- configuration at 1,
- data at 2,
- command/transmit level at 3.

Reading the data register pops the oldest received character. Writing it queues a transmit byte. The deserializer offers characters with a one-cycle strobe. The serializer sees a valid flag and the head byte, and it takes bytes with a one-cycle strobe. A character-time tick from the baud logic drives the receive timeout.

Top module: `uart_fifo_irq_ctrl`

## Requirements
- R1: After reset both queues are empty, all enables are zero and `irq` is low. Address 0 then reads 0x18, and the thresholds read back as DEPTH/2 with a timeout limit of 1.
- R2: Status bits at address 0 are laid out as follows:
  - bit 0: overrun
  - bit 1: receive level above threshold
  - bit 2: receive timeout
  - bit 3: transmit empty
  - bit 4: transmit below threshold
  - bit 5: receive not empty

  Bits 12:8 hold the enables for sources 0..4. A write to address 0 replaces the enables from bits 12:8, so writing zero disables every source.
- R3: `irq` is high exactly when some status bit among 4:0 has its enable bit set.
- R4: A read of address 2 with received data present returns the character in bits 7:0 with bit 8 (valid) set. Bit 9 is break, bit 10 is parity error and bit 11 is framing error. The read removes that character. A read with no data returns 0 and removes nothing. Characters leave in arrival order.
- R5: The receive-above bit is set while the receive count is strictly greater than configuration bits 4:0.
- R6: The receive timeout bit is set when the receive queue is non-empty and the number of character ticks since the last push or pop is at least configuration bits 19:16. The tick count restarts on every push or pop and is held at zero while the queue is empty.
- R7: A received character that arrives while the receive queue is full, with no pop in the same cycle, is dropped and sets the overrun bit. Writes to address 0 leave the overrun bit set. Only a receive flush clears it.
- R8: A receive push and a software pop in the same cycle on a full queue both take effect. The new character is stored behind the others and overrun stays clear.
- R9: A write to address 2 queues bits 7:0 for transmit, unless the transmit queue is full, in which case the byte is dropped. Address 3 reads the transmit occupancy in bits 4:0. Transmit-empty is set at zero occupancy, and transmit-below is set while the occupancy is less than configuration bits 12:8.
- R10: `txValid` is high while the transmit queue holds data and `txData` shows its oldest byte. A `txTake` pulse removes that byte.
- R11: Writing address 3 with bit 0 set empties the receive queue. Writing it with bit 1 set empties the transmit queue.
- R12: Address 1 stores the receive threshold in bits 4:0, the transmit threshold in bits 12:8 and the timeout limit in bits 19:16, and reads them back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe; pops received data at address 2 |
| regAddr | input | 2 | Register select |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, combinational from address |
| rxStrobe | input | 1 | Deserializer delivers a character this cycle |
| rxChar | input | 8 | Received character |
| rxBreak | input | 1 | Break detected on this character |
| rxParErr | input | 1 | Parity error on this character |
| rxFrmErr | input | 1 | Framing error on this character |
| charTick | input | 1 | One pulse per character time |
| txValid | output | 1 | Transmit byte available |
| txData | output | 8 | Oldest transmit byte |
| txTake | input | 1 | Serializer takes the oldest byte |
| irq | output | 1 | Combined enabled interrupt |

## Verification
The delicate coincidence is a deserializer push landing in the same cycle as a software pop of a completely full receive queue. The bench fills the queue to sixteen entries, then raises `rxStrobe` and a data-register read on the same clock edge. It then judges three things:
- the read returned the oldest character,
- the status read that follows shows no overrun,
- draining the queue yields the fifteen remaining characters followed by the new one, then an empty read.

The contrasting case is a push into a full queue with no pop. That must drop the character and latch overrun, and the overrun must survive a status write.

// File: rtl/ufic_pkg.sv
package ufic_pkg;
  localparam logic [1:0] ADDR_IRQ  = 2'd0;
  localparam logic [1:0] ADDR_CFG  = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
  localparam logic [1:0] ADDR_CMD  = 2'd3;

  localparam int SRC_OVR     = 0;
  localparam int SRC_RXABOVE = 1;
  localparam int SRC_RXTMO   = 2;
  localparam int SRC_TXEMPTY = 3;
  localparam int SRC_TXBELOW = 4;
  localparam int NUM_SRC     = 5;
  localparam int STAT_RXNE   = 5;

  localparam int RX_WORD_W = 11;  // {frame, parity, break, char[7:0]}
  localparam int MASK_LSB  = 8;
  localparam int TXTH_LSB  = 8;
  localparam int TMO_LSB   = 16;

  typedef struct packed {
    logic rxPush;
    logic rxPop;
    logic rxFlush;
    logic txPush;
    logic txPop;
    logic txFlush;
  } fifoCmd_t;
endpackage

// File: rtl/ufic_fifo.sv
module ufic_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] headData,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign headData = mem[rdPtr];
  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
endmodule

// File: rtl/ufic_datapath.sv
module ufic_datapath import ufic_pkg::*; #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  fifoCmd_t             cmd,
  input  logic [RX_WORD_W-1:0] rxWord,
  input  logic [7:0]           txByte,
  output logic [RX_WORD_W-1:0] rxHead,
  output logic [CW-1:0]        rxCount,
  output logic                 rxFull,
  output logic                 rxEmpty,
  output logic [7:0]           txHead,
  output logic [CW-1:0]        txCount,
  output logic                 txFull,
  output logic                 txEmpty
);
  ufic_fifo #(.WIDTH(RX_WORD_W), .DEPTH(DEPTH)) rxFifo_i (
    .clk(clk), .rstN(rstN), .push(cmd.rxPush), .pop(cmd.rxPop), .flush(cmd.rxFlush),
    .wrData(rxWord), .headData(rxHead), .count(rxCount), .full(rxFull), .empty(rxEmpty)
  );

  ufic_fifo #(.WIDTH(8), .DEPTH(DEPTH)) txFifo_i (
    .clk(clk), .rstN(rstN), .push(cmd.txPush), .pop(cmd.txPop), .flush(cmd.txFlush),
    .wrData(txByte), .headData(txHead), .count(txCount), .full(txFull), .empty(txEmpty)
  );
endmodule

// File: rtl/ufic_control.sv
module ufic_control import ufic_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int TMO_W = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic [1:0]           regAddr,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  input  logic                 rxStrobe,
  input  logic                 txTake,
  input  logic                 charTick,
  input  logic [RX_WORD_W-1:0] rxHead,
  input  logic [CW-1:0]        rxCount,
  input  logic                 rxFull,
  input  logic                 rxEmpty,
  input  logic [CW-1:0]        txCount,
  input  logic                 txFull,
  input  logic                 txEmpty,
  output fifoCmd_t             cmd,
  output logic                 overrun,
  output logic                 irq
);
  logic [NUM_SRC-1:0] srcMask;
  logic [CW-1:0]      rxThresh, txThresh;
  logic [TMO_W-1:0]   tmoLimit, tmoCnt;
  logic [STAT_RXNE:0] status;
  logic wrIrq, wrCfg, wrData, wrCmd, rdData;
  logic unusedWrBits;

  assign wrIrq  = regWrEn && (regAddr == ADDR_IRQ);
  assign wrCfg  = regWrEn && (regAddr == ADDR_CFG);
  assign wrData = regWrEn && (regAddr == ADDR_DATA);
  assign wrCmd  = regWrEn && (regAddr == ADDR_CMD);
  assign rdData = regRdEn && (regAddr == ADDR_DATA);
  assign unusedWrBits = ^regWrData;

  // strobes to the datapath; a flush takes priority inside the queues
  always_comb begin
    cmd.rxFlush = wrCmd && regWrData[0];
    cmd.txFlush = wrCmd && regWrData[1];
    cmd.rxPop   = rdData && !rxEmpty;
    cmd.rxPush  = rxStrobe && (!rxFull || cmd.rxPop);
    cmd.txPush  = wrData && !txFull;
    cmd.txPop   = txTake && !txEmpty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcMask  <= '0;
      rxThresh <= CW'(DEPTH / 2);
      txThresh <= CW'(DEPTH / 2);
      tmoLimit <= TMO_W'(1);
    end else begin
      if (wrIrq) srcMask <= regWrData[MASK_LSB +: NUM_SRC];
      if (wrCfg) begin
        rxThresh <= regWrData[CW-1:0];
        txThresh <= regWrData[TXTH_LSB +: CW];
        tmoLimit <= regWrData[TMO_LSB +: TMO_W];
      end
    end
  end

  // overrun: sticky until a receive flush
  always_ff @(posedge clk) begin
    if (!rstN || cmd.rxFlush) overrun <= 1'b0;
    else if (rxStrobe && rxFull && !cmd.rxPop) overrun <= 1'b1;
  end

  // character-time counter since the last receive queue movement
  always_ff @(posedge clk) begin
    if (!rstN || cmd.rxFlush || cmd.rxPush || cmd.rxPop || rxEmpty) tmoCnt <= '0;
    else if (charTick && (tmoCnt != '1)) tmoCnt <= tmoCnt + 1'b1;
  end

  always_comb begin
    status              = '0;
    status[SRC_OVR]     = overrun;
    status[SRC_RXABOVE] = rxCount > rxThresh;
    status[SRC_RXTMO]   = !rxEmpty && (tmoCnt >= tmoLimit);
    status[SRC_TXEMPTY] = txEmpty;
    status[SRC_TXBELOW] = txCount < txThresh;
    status[STAT_RXNE]   = !rxEmpty;
  end

  assign irq = |(status[NUM_SRC-1:0] & srcMask);

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_IRQ: begin
        regRdData[STAT_RXNE:0]               = status;
        regRdData[MASK_LSB +: NUM_SRC]       = srcMask;
      end
      ADDR_CFG: begin
        regRdData[CW-1:0]                    = rxThresh;
        regRdData[TXTH_LSB +: CW]            = txThresh;
        regRdData[TMO_LSB +: TMO_W]          = tmoLimit;
      end
      ADDR_DATA: begin
        if (!rxEmpty) regRdData[11:0] = {rxHead[10:8], 1'b1, rxHead[7:0]};
      end
      default: regRdData[CW-1:0] = txCount;
    endcase
  end
endmodule

// File: rtl/uart_fifo_irq_ctrl.sv
module uart_fifo_irq_ctrl import ufic_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int TMO_W = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        rxStrobe,
  input  logic [7:0]  rxChar,
  input  logic        rxBreak,
  input  logic        rxParErr,
  input  logic        rxFrmErr,
  input  logic        charTick,
  output logic        txValid,
  output logic [7:0]  txData,
  input  logic        txTake,
  output logic        irq
);
  localparam int CW = $clog2(DEPTH + 1);

  fifoCmd_t             cmd;
  logic [RX_WORD_W-1:0] rxHead;
  logic [CW-1:0]        rxCount, txCount;
  logic                 rxFull, rxEmpty, txFull, txEmpty, overrun;
  logic [7:0]           txHead;

  ufic_control #(.DEPTH(DEPTH), .TMO_W(TMO_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .rxStrobe(rxStrobe), .txTake(txTake),
    .charTick(charTick), .rxHead(rxHead), .rxCount(rxCount), .rxFull(rxFull),
    .rxEmpty(rxEmpty), .txCount(txCount), .txFull(txFull), .txEmpty(txEmpty),
    .cmd(cmd), .overrun(overrun), .irq(irq)
  );

  ufic_datapath #(.DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .rxWord({rxFrmErr, rxParErr, rxBreak, rxChar}), .txByte(regWrData[7:0]),
    .rxHead(rxHead), .rxCount(rxCount), .rxFull(rxFull), .rxEmpty(rxEmpty),
    .txHead(txHead), .txCount(txCount), .txFull(txFull), .txEmpty(txEmpty)
  );

  assign txValid = !txEmpty;
  assign txData  = txHead;
endmodule

// File: rtl/ufic_checker.sv
module ufic_checker import ufic_pkg::*; #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input fifoCmd_t      cmd,
  input logic          rxStrobe,
  input logic          rxFull,
  input logic [CW-1:0] rxCount,
  input logic [CW-1:0] txCount,
  input logic          overrun,
  input logic          txValid,
  input logic          irq,
  input logic          regWrEn,
  input logic [1:0]    regAddr,
  input logic [31:0]   regWrData
);
  logic unusedCmd;
  assign unusedCmd = cmd.rxPush ^ cmd.txPop;

  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overrun && !cmd.rxFlush |=> overrun);
  a_r7_overrun_set: assert property (@(posedge clk) disable iff (!rstN)
    rxStrobe && rxFull && !cmd.rxPop && !cmd.rxFlush |=> overrun);
  a_r8_swap_no_overrun: assert property (@(posedge clk) disable iff (!rstN)
    !overrun && rxStrobe && rxFull && cmd.rxPop && !cmd.rxFlush |=> !overrun && rxFull);
  a_r11_rx_flush_empty: assert property (@(posedge clk) disable iff (!rstN)
    cmd.rxFlush |=> rxCount == '0);
  a_r11_tx_flush_empty: assert property (@(posedge clk) disable iff (!rstN)
    cmd.txFlush |=> txCount == '0);
  a_r2_zero_mask_quiet: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regAddr == ADDR_IRQ && regWrData[MASK_LSB +: NUM_SRC] == '0 |=> !irq);
  a_r10_valid_tracks_level: assert property (@(posedge clk) disable iff (!rstN)
    txValid == (txCount != '0));
  a_r9_tx_push_grows: assert property (@(posedge clk) disable iff (!rstN)
    cmd.txPush && !cmd.txPop && !cmd.txFlush |=> txCount == CW'($past(txCount) + 1'b1));
  a_r9_tx_bounded: assert property (@(posedge clk) disable iff (!rstN)
    txCount <= CW'(DEPTH));
endmodule

bind uart_fifo_irq_ctrl ufic_checker #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rstN(rstN), .cmd(cmd), .rxStrobe(rxStrobe), .rxFull(rxFull),
  .rxCount(rxCount), .txCount(txCount), .overrun(overrun), .txValid(txValid),
  .irq(irq), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData)
);

// File: tb/uart_fifo_irq_ctrl_tb.sv
module uart_fifo_irq_ctrl_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic rxStrobe = 1'b0, rxBreak = 1'b0, rxParErr = 1'b0, rxFrmErr = 1'b0;
  logic [7:0] rxChar = '0;
  logic charTick = 1'b0, txTake = 1'b0;
  logic txValid, irq;
  logic [7:0] txData;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;  // 125 MHz

  uart_fifo_irq_ctrl dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .rxStrobe(rxStrobe), .rxChar(rxChar),
    .rxBreak(rxBreak), .rxParErr(rxParErr), .rxFrmErr(rxFrmErr), .charTick(charTick),
    .txValid(txValid), .txData(txData), .txTake(txTake), .irq(irq)
  );

  // vector: {req[7:0], op[1:0], addr[1:0], data[31:0], expect[31:0]}
  // op 0 write, 1 read and compare, 2 deserializer push of data[10:0], 3 data character ticks
  localparam int NV = 29;
  localparam logic [75:0] VEC [NV] = '{
    {8'd1,  2'd1, 2'd0, 32'h0,        32'h18},        // R1 reset status
    {8'd12, 2'd0, 2'd1, 32'h00020302, 32'h0},
    {8'd12, 2'd1, 2'd1, 32'h0,        32'h00020302},  // R12 readback
    {8'd2,  2'd0, 2'd0, 32'h1F00,     32'h0},
    {8'd2,  2'd1, 2'd0, 32'h0,        32'h1F18},      // R2 enables
    {8'd4,  2'd2, 2'd0, 32'h241,      32'h0},
    {8'd2,  2'd1, 2'd0, 32'h0,        32'h1F38},      // R2 not-empty bit
    {8'd4,  2'd1, 2'd2, 32'h0,        32'h541},       // R4 parity flag
    {8'd4,  2'd1, 2'd2, 32'h0,        32'h0},         // R4 empty read
    {8'd4,  2'd2, 2'd0, 32'h010,      32'h0},
    {8'd4,  2'd2, 2'd0, 32'h111,      32'h0},
    {8'd4,  2'd2, 2'd0, 32'h412,      32'h0},
    {8'd5,  2'd1, 2'd0, 32'h0,        32'h1F3A},      // R5 3 > 2
    {8'd4,  2'd1, 2'd2, 32'h0,        32'h110},
    {8'd4,  2'd1, 2'd2, 32'h0,        32'h311},       // R4 break flag
    {8'd4,  2'd1, 2'd2, 32'h0,        32'h912},       // R4 framing flag
    {8'd9,  2'd0, 2'd2, 32'hAA,       32'h0},
    {8'd9,  2'd0, 2'd2, 32'hBB,       32'h0},
    {8'd9,  2'd1, 2'd3, 32'h0,        32'h2},         // R9 fill level
    {8'd9,  2'd1, 2'd0, 32'h0,        32'h1F10},      // R9 below threshold
    {8'd9,  2'd0, 2'd2, 32'hCC,       32'h0},
    {8'd9,  2'd1, 2'd0, 32'h0,        32'h1F00},      // R9 at threshold
    {8'd6,  2'd2, 2'd0, 32'h055,      32'h0},
    {8'd6,  2'd3, 2'd0, 32'd1,        32'h0},
    {8'd6,  2'd1, 2'd0, 32'h0,        32'h1F20},      // R6 one tick, below limit
    {8'd6,  2'd3, 2'd0, 32'd1,        32'h0},
    {8'd6,  2'd1, 2'd0, 32'h0,        32'h1F24},      // R6 limit reached
    {8'd4,  2'd1, 2'd2, 32'h0,        32'h155},
    {8'd6,  2'd1, 2'd0, 32'h0,        32'h1F00}       // R6 cleared when empty
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1;
    check(regRdData == exp, req, regRdData, exp);
    if (a == 2'd0) check(irq == |(exp[4:0] & exp[12:8]), "R3 irq", 32'(irq), 32'(|(exp[4:0] & exp[12:8])));
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic rxPush(input logic [10:0] w);
    @(negedge clk);
    rxStrobe = 1'b1; rxChar = w[7:0]; rxBreak = w[8]; rxParErr = w[9]; rxFrmErr = w[10];
    @(negedge clk);
    rxStrobe = 1'b0; rxBreak = 1'b0; rxParErr = 1'b0; rxFrmErr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); charTick = 1'b1;
      @(negedge clk); charTick = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check(irq == 1'b0 && txValid == 1'b0, "R1 outputs", {30'd0, irq, txValid}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] req;
      logic [1:0] op, a;
      logic [31:0] d, e;
      {req, op, a, d, e} = VEC[i];
      case (op)
        2'd0: regWrite(a, d);
        2'd1: regRead(a, e, $sformatf("R%0d vector %0d", req, i));
        2'd2: rxPush(d[10:0]);
        default: ticks(int'(d));
      endcase
    end

    // R10: serializer side
    #1;
    check(txValid && txData == 8'hAA, "R10 head", {23'd0, txValid, txData}, 32'h1AA);
    @(negedge clk); txTake = 1'b1;
    @(negedge clk); txTake = 1'b0;
    #1;
    check(txData == 8'hBB, "R10 after take", 32'(txData), 32'hBB);
    regRead(2'd3, 32'h2, "R10 level after take");

    // R11: transmit flush
    regWrite(2'd3, 32'h2);
    regRead(2'd3, 32'h0, "R11 tx flushed");
    check(!txValid, "R11 txValid", 32'(txValid), 32'h0);
    regRead(2'd0, 32'h1F18, "R11 tx status after flush");

    // R9: transmit full drops the extra byte
    for (int i = 0; i < 17; i++) regWrite(2'd2, 32'(i));
    regRead(2'd3, 32'd16, "R9 full level");
    #1;
    check(txData == 8'h00, "R9 head kept", 32'(txData), 32'h0);
    regWrite(2'd3, 32'h2);

    // R7: overrun sticky, cleared only by receive flush
    regWrite(2'd1, 32'h00020310);
    for (int i = 0; i < 17; i++) rxPush(11'(i));
    regRead(2'd0, 32'h1F39, "R7 overrun set");
    regWrite(2'd0, 32'h1F00);
    regRead(2'd0, 32'h1F39, "R7 status write keeps overrun");
    regRead(2'd2, 32'h100, "R7 oldest kept");
    regRead(2'd0, 32'h1F39, "R7 pop keeps overrun");
    regWrite(2'd3, 32'h1);
    regRead(2'd0, 32'h1F18, "R7 flush clears");
    regRead(2'd2, 32'h0, "R11 rx flushed");

    // R8: push and pop together on a full receive queue
    for (int i = 0; i < 16; i++) rxPush(11'(8'h20 + i));
    @(negedge clk);
    rxStrobe = 1'b1; rxChar = 8'h7E; regRdEn = 1'b1; regAddr = 2'd2;
    #1;
    check(regRdData == 32'h120, "R8 pop value", regRdData, 32'h120);
    @(negedge clk);
    rxStrobe = 1'b0; regRdEn = 1'b0;
    regRead(2'd0, 32'h1F38, "R8 no overrun");
    for (int i = 1; i < 16; i++) regRead(2'd2, 32'h100 + 32'(8'h20 + i), "R8 order");
    regRead(2'd2, 32'h17E, "R8 new char stored last");
    regRead(2'd2, 32'h0, "R8 drained");

    // R2/R3: zero enables silence irq, single enable raises it
    regWrite(2'd0, 32'h0);
    rxPush(11'h033);
    ticks(2);
    regRead(2'd0, 32'h003C, "R2 all disabled");
    regWrite(2'd0, 32'h0400);
    regRead(2'd0, 32'h043C, "R3 timeout enabled");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule